// File: doc/BRIEF.md
# Tile Chain Frame Loader with Enable Dimming

This controller feeds a chain of cascaded display tiles from the host side. Each tile holds a serial shift register, a latch and dot drivers. When `start_i` is seen, the controller reads the frame one bit at a time from a frame-buffer read port and shifts each bit out on a serial clock and data pair. It then pulses the latch line so that the whole chain shows the new image at once. The chain is `TILE_DOTS * TILE_COLS * TILE_ROWS` bits long. A two-row array is wired as one long chain: the serial output of the upper row feeds the serial input of the lower row.

Brightness comes from a pulse-width-modulated enable line. A period has 256 steps of `PWM_STEP_CYC` system cycles each. The enable is high for the first L steps, where L is the 8-bit level taken at the start of the period. A blink request taken at that same point holds the enable low for the whole period, and the loaded data stays in place. The modulator is frozen for as long as a transfer is in progress, so the enable never changes level while bits move through the chain.

The serial clock half period is the largest of three values: the requested count, the count needed to keep the serial clock at or below `SCLK_MAX_HZ`, and 3.

Top module: `tile_chain_loader`

## Requirements
- R1: While `rst_n` is low, `sclk_o`, `si_o`, `lat_o`, `en_o`, `busy_o`, `done_o` and `fb_addr_o` are all 0.
- R2: A `start_i` sampled high while idle makes `busy_o` high from the next cycle. Each bit then takes 2H cycles, with `sclk_o` low for the first H cycles and high for the last H. H = max(`HALF_REQ`, ceil(`SYS_CLK_HZ`/(2*`SCLK_MAX_HZ`)), 3).
- R3: Bits go out in address order 0 to N-1. During bit k, `fb_addr_o` equals k. The read port returns `fb_data_i` one cycle after the address. `si_o` carries the data of bit k from the third cycle of that bit and stays stable while `sclk_o` is high.
- R4: Right after the high phase of the last bit, `lat_o` is high for exactly 2H cycles, and `sclk_o` stays low during that time.
- R5: In the first cycle after `lat_o` falls, `done_o` is high for one cycle and `busy_o` is already low. A new start is accepted in that same cycle.
- R6: `start_i` while `busy_o` is high has no effect: the frame runs on unchanged and no second frame follows.
- R7: While idle, the PWM advances one step every `PWM_STEP_CYC` cycles, modulo 256. `en_o` is high exactly while the step index is below the level latched from `level_i` when the step wraps to 0, giving a duty of L/256. The level is 0 after reset.
- R8: `blink_i` sampled when the step wraps to 0 holds `en_o` low for that whole period.
- R9: While `busy_o` is high, the PWM step and `en_o` hold their values. They resume from that point once `busy_o` falls.
- R10: One frame makes exactly `TILE_DOTS*TILE_COLS*TILE_ROWS` rising edges on `sclk_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to load one frame |
| level_i | input | 8 | Brightness level, duty L/256 |
| blink_i | input | 1 | Blank the display for the next PWM period |
| fb_addr_o | output | ADDR_W | Frame-buffer bit address |
| fb_data_i | input | 1 | Frame-buffer bit, one cycle after the address |
| sclk_o | output | 1 | Serial shift clock to the chain |
| si_o | output | 1 | Serial data to the chain (1 = dot on) |
| lat_o | output | 1 | Latch pulse to the chain |
| en_o | output | 1 | PWM display enable |
| busy_o | output | 1 | Transfer or latch in progress |
| done_o | output | 1 | One-cycle pulse at the end of a frame |

## Verification
A phase or bit counter that drifts shows up within one bit period, either as a misplaced `sclk_o` edge or as a wrong `fb_addr_o`. A bit taken from the wrong address shows up as a wrong `si_o` value in the middle of that bit. A latch state entered too early or left too late moves `lat_o` and `done_o` by whole cycles, and the rising-edge count per frame reports it. A PWM counter or level register that advances during a transfer, or that loads away from the wrap, corrupts `en_o` on the next step. The bench compares every output on every cycle against a timing model built from positions and counts, so any of these faults is reported in the cycle where it first appears.

// File: rtl/tcl_pkg.sv
package tcl_pkg;
  typedef enum logic [1:0] {
    LD_IDLE  = 2'd0,
    LD_SHIFT = 2'd1,
    LD_LATCH = 2'd2
  } ld_state_e;
endpackage

// File: rtl/tcl_pwm.sv
module tcl_pwm #(
  parameter int STEP_CYC = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       freeze_i,
  input  logic [7:0] level_i,
  input  logic       blink_i,
  output logic       en_o
);
  logic       run;
  logic       step_tick;
  logic [7:0] cnt_q, cnt_d;
  logic [7:0] lvl_q, lvl_d;
  logic       blk_q, blk_d;

  assign run = !freeze_i;

  generate
    if (STEP_CYC > 1) begin : g_pre
      localparam int PW = $clog2(STEP_CYC);
      localparam logic [PW-1:0] PRE_LAST = PW'(STEP_CYC - 1);
      logic [PW-1:0] pre_q, pre_d;
      always_comb begin
        pre_d = pre_q;
        if (run) pre_d = (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
      end
      assign step_tick = run && (pre_q == PRE_LAST);
    end else begin : g_nopre
      assign step_tick = run;
    end
  endgenerate

  // period-boundary capture of level and blank
  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    blk_d = blk_q;
    if (step_tick) begin
      cnt_d = cnt_q + 8'd1;
      if (cnt_q == 8'hFF) begin
        lvl_d = level_i;
        blk_d = blink_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= '0;
      blk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
      blk_q <= blk_d;
    end
  end

  assign en_o = !blk_q && (cnt_q < lvl_q);

  // R9: enable holds across cycles of a running transfer
  p_en_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_i && $past(freeze_i)) |-> $stable(en_o));

  // R7: level only changes when the step wraps to 0
  p_lvl_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != 8'd0) |-> $stable(lvl_q));
endmodule

// File: rtl/tcl_shifter.sv
module tcl_shifter
  import tcl_pkg::*;
#(
  parameter int CHAIN_BITS = 4096,
  parameter int ADDR_W     = 12,
  parameter int HALF_CYC   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic [ADDR_W-1:0] fb_addr_o,
  input  logic              fb_data_i,
  output logic              sclk_o,
  output logic              si_o,
  output logic              lat_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int PH_W = $clog2(2 * HALF_CYC);
  localparam logic [PH_W-1:0]   PH_LAST  = PH_W'(2 * HALF_CYC - 1);
  localparam logic [PH_W-1:0]   PH_HIGH  = PH_W'(HALF_CYC);
  localparam logic [PH_W-1:0]   PH_GRAB  = PH_W'(1);
  localparam logic [ADDR_W-1:0] BIT_LAST = ADDR_W'(CHAIN_BITS - 1);

  ld_state_e         state_q, state_d;
  logic [PH_W-1:0]   ph_q, ph_d;
  logic [ADDR_W-1:0] bit_q, bit_d;
  logic              si_q, si_d;
  logic              done_q, done_d;
  logic              cnt_en;

  // counters only move while a frame runs or starts
  assign cnt_en = (state_q != LD_IDLE) || start_i;

  always_comb begin
    state_d = state_q;
    ph_d    = ph_q;
    bit_d   = bit_q;
    si_d    = si_q;
    done_d  = 1'b0;
    unique case (state_q)
      LD_IDLE: begin
        if (start_i) begin
          state_d = LD_SHIFT;
          ph_d    = '0;
          bit_d   = '0;
        end
      end
      LD_SHIFT: begin
        if (ph_q == PH_GRAB) si_d = fb_data_i;
        if (ph_q == PH_LAST) begin
          ph_d = '0;
          if (bit_q == BIT_LAST) state_d = LD_LATCH;
          else                   bit_d   = bit_q + 1'b1;
        end else begin
          ph_d = ph_q + 1'b1;
        end
      end
      LD_LATCH: begin
        if (ph_q == PH_LAST) begin
          ph_d    = '0;
          state_d = LD_IDLE;
          done_d  = 1'b1;
        end else begin
          ph_d = ph_q + 1'b1;
        end
      end
      default: state_d = LD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LD_IDLE;
      ph_q    <= '0;
      bit_q   <= '0;
      si_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      si_q    <= si_d;
      if (cnt_en) begin
        ph_q  <= ph_d;
        bit_q <= bit_d;
      end
    end
  end

  assign fb_addr_o = bit_q;
  assign si_o      = si_q;
  assign sclk_o    = (state_q == LD_SHIFT) && (ph_q >= PH_HIGH);
  assign lat_o     = (state_q == LD_LATCH);
  assign busy_o    = (state_q != LD_IDLE);
  assign done_o    = done_q;

  // R3: data never moves while the shift clock is high
  p_si_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> $stable(si_o));

  // R3: every frame begins at address 0
  p_addr_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (fb_addr_o == '0));

  // R4: latch opens straight after a high shift phase
  p_lat_after_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lat_o) |-> $past(sclk_o));

  // R5: done only after latch has closed
  p_done_after_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(lat_o) && !lat_o && !busy_o));
endmodule

// File: rtl/tile_chain_loader.sv
module tile_chain_loader #(
  parameter int SYS_CLK_HZ   = 250_000_000,
  parameter int SCLK_MAX_HZ  = 4_000_000,
  parameter int HALF_REQ     = 32,
  parameter int TILE_DOTS    = 256,
  parameter int TILE_COLS    = 16,
  parameter int TILE_ROWS    = 1,
  parameter int PWM_STEP_CYC = 64,
  localparam int CHAIN_BITS  = TILE_DOTS * TILE_COLS * TILE_ROWS,
  localparam int ADDR_W      = (CHAIN_BITS > 1) ? $clog2(CHAIN_BITS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [7:0]        level_i,
  input  logic              blink_i,
  output logic [ADDR_W-1:0] fb_addr_o,
  input  logic              fb_data_i,
  output logic              sclk_o,
  output logic              si_o,
  output logic              lat_o,
  output logic              en_o,
  output logic              busy_o,
  output logic              done_o
);
  // half period clamped so the serial clock never exceeds its limit
  localparam int HALF_MIN = (SYS_CLK_HZ + 2 * SCLK_MAX_HZ - 1) / (2 * SCLK_MAX_HZ);
  localparam int HALF_A   = (HALF_REQ > HALF_MIN) ? HALF_REQ : HALF_MIN;
  localparam int HALF_CYC = (HALF_A > 3) ? HALF_A : 3;

  logic busy_w;

  tcl_shifter #(
    .CHAIN_BITS(CHAIN_BITS),
    .ADDR_W    (ADDR_W),
    .HALF_CYC  (HALF_CYC)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .fb_addr_o(fb_addr_o),
    .fb_data_i(fb_data_i),
    .sclk_o   (sclk_o),
    .si_o     (si_o),
    .lat_o    (lat_o),
    .busy_o   (busy_w),
    .done_o   (done_o)
  );

  tcl_pwm #(
    .STEP_CYC(PWM_STEP_CYC)
  ) u_pwm (
    .clk     (clk),
    .rst_n   (rst_n),
    .freeze_i(busy_w),
    .level_i (level_i),
    .blink_i (blink_i),
    .en_o    (en_o)
  );

  assign busy_o = busy_w;
endmodule

// File: tb/tb_tile_chain_loader.sv
`timescale 1ns/1ps
module tb_tile_chain_loader;
  localparam int SYS   = 24_000_000;
  localparam int HREQ  = 1;
  localparam int DOTS  = 8;
  localparam int COLS  = 1;
  localparam int ROWS  = 2;
  localparam int STEP  = 1;
  localparam int N     = DOTS * COLS * ROWS;
  localparam int HMIN  = (SYS + 8_000_000 - 1) / 8_000_000;
  localparam int H     = (HREQ > HMIN) ? ((HREQ > 3) ? HREQ : 3) : ((HMIN > 3) ? HMIN : 3);
  localparam int P2    = 2 * H;
  localparam int SHIFT_CYC = N * P2;
  localparam int FRAME_CYC = SHIFT_CYC + P2;
  localparam int PERIOD    = 256 * STEP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [7:0] level_i = 8'd64;
  logic blink_i = 1'b0;
  logic [3:0] fb_addr_o;
  logic fb_data_i = 1'b0;
  logic sclk_o, si_o, lat_o, en_o, busy_o, done_o;

  logic mem [0:N-1];

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  tile_chain_loader #(
    .SYS_CLK_HZ(SYS), .SCLK_MAX_HZ(4_000_000), .HALF_REQ(HREQ),
    .TILE_DOTS(DOTS), .TILE_COLS(COLS), .TILE_ROWS(ROWS), .PWM_STEP_CYC(STEP)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .level_i(level_i),
    .blink_i(blink_i), .fb_addr_o(fb_addr_o), .fb_data_i(fb_data_i),
    .sclk_o(sclk_o), .si_o(si_o), .lat_o(lat_o), .en_o(en_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  // frame buffer with one cycle read latency
  always @(posedge clk) fb_data_i <= mem[fb_addr_o];

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // reference model: positions and counts
  int m_t = 0, m_pt = 0, m_lvl = 0;
  bit m_busy = 0, m_done = 0, m_blk = 0;

  always @(posedge clk) begin
    bit was_busy;
    if (!rst_n) begin
      m_t = 0; m_pt = 0; m_lvl = 0; m_busy = 0; m_done = 0; m_blk = 0;
    end else begin
      was_busy = m_busy;
      if (m_busy) begin
        if (m_t == FRAME_CYC - 1) begin m_busy = 0; m_done = 1; end
        else m_t++;
      end else begin
        m_done = 0;
        if (start_i) begin m_busy = 1; m_t = 0; end
      end
      if (!was_busy) begin
        m_pt++;
        if (m_pt % PERIOD == 0) begin m_lvl = level_i; m_blk = blink_i; end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  bit compare_on = 0;
  bit prev_sclk = 0;
  int rises = 0;
  always @(negedge clk) begin
    int b, w, step;
    bit es, el, ee;
    cycles++;
    if (rst_n && compare_on) begin
      es = 0; el = 0;
      if (m_busy) begin
        if (m_t < SHIFT_CYC) begin
          b = m_t / P2; w = m_t % P2;
          es = (w >= H);
          chk("R3", "fb_addr_o", fb_addr_o, b);
          if (w >= 2) chk("R3", "si_o", si_o, mem[b]);
        end else el = 1;
      end
      chk("R2", "sclk_o", sclk_o, es);
      chk("R4", "lat_o", lat_o, el);
      chk("R5", "busy_o", busy_o, m_busy);
      chk("R5", "done_o", done_o, m_done);
      step = (m_pt / STEP) % 256;
      ee = !m_blk && (step < m_lvl);
      if (m_blk)       chk("R8", "en_o", en_o, ee);
      else if (m_busy) chk("R9", "en_o", en_o, ee);
      else             chk("R7", "en_o", en_o, ee);
    end
    if (sclk_o && !prev_sclk) rises++;
    prev_sclk = sclk_o;
  end

  // watchdog
  always @(negedge clk) begin
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      finish_sim();
    end
  end

  task automatic run_frame(input bit extra_start, input bit chain_next);
    int guard = 0;
    bit en0;
    bit en_moved = 0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    rises = (sclk_o ? 1 : 0);
    en0 = en_o;
    while (!done_o && guard < 4 * FRAME_CYC) begin
      if (en_o != en0) en_moved = 1;
      if (extra_start && guard == FRAME_CYC / 3) start_i = 1'b1;   // R6 stimulus
      else start_i = 1'b0;
      if (extra_start && guard == FRAME_CYC / 2) level_i = 8'd200;
      @(negedge clk); guard++;
    end
    start_i = 1'b0;
    chk("R5", "done seen", done_o, 1);
    chk("R5", "busy at done", busy_o, 0);
    chk("R10", "sclk rises per frame", rises, N);
    chk("R9", "en moved during transfer", en_moved, 0);
    if (chain_next) start_i = 1'b1;  // start in the done cycle
  endtask

  task automatic count_en(input int len, output int hi);
    hi = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (en_o) hi++;
    end
  endtask

  initial begin
    int hi;
    for (int i = 0; i < N; i++) mem[i] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "sclk_o", sclk_o, 0);
    chk("R1", "si_o", si_o, 0);
    chk("R1", "lat_o", lat_o, 0);
    chk("R1", "en_o", en_o, 0);
    chk("R1", "busy_o", busy_o, 0);
    chk("R1", "done_o", done_o, 0);
    chk("R1", "fb_addr_o", fb_addr_o, 0);
    rst_n = 1'b1;
    compare_on = 1;

    // PWM duty after the first wrap
    repeat (300) @(negedge clk);
    count_en(PERIOD, hi);
    chk("R7", "en high count level 64", hi, 64);

    // frame with mixed pattern, extra start and level change while busy
    for (int i = 0; i < N; i++) mem[i] = ((i * 5 + 1) % 3 == 0);
    run_frame(1, 0);
    repeat (4) @(negedge clk);
    chk("R6", "no second frame", busy_o, 0);

    // all-ones frame at full level
    level_i = 8'd255;
    for (int i = 0; i < N; i++) mem[i] = 1'b1;
    repeat (400) @(negedge clk);
    run_frame(0, 0);

    // blink holds enable low for whole periods
    blink_i = 1'b1;
    repeat (2 * PERIOD + 10) @(negedge clk);
    count_en(PERIOD, hi);
    chk("R8", "en high count during blink", hi, 0);
    blink_i = 1'b0;

    // level 0, all-zeros frame
    level_i = 8'd0;
    for (int i = 0; i < N; i++) mem[i] = 1'b0;
    repeat (PERIOD + 20) @(negedge clk);
    count_en(PERIOD, hi);
    chk("R7", "en high count level 0", hi, 0);
    run_frame(0, 0);

    // back-to-back frames, each started in the done cycle
    level_i = 8'd128;
    for (int i = 0; i < N; i++) mem[i] = (i % 2 == 0);
    repeat (137) @(negedge clk);
    run_frame(0, 1);
    @(negedge clk); start_i = 1'b0;
    chk("R5", "restart in done cycle busy", busy_o, 1);
    begin
      int guard = 0;
      while (!done_o && guard < 4 * FRAME_CYC) begin @(negedge clk); guard++; end
      chk("R5", "second chained frame done", done_o, 1);
    end
    repeat (PERIOD + 50) @(negedge clk);
    finish_sim();
  end
endmodule